// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the end of a cable-receiver decode chain. It takes decoded MPEG-2 transport bytes and puts them on the chip's output port. Each byte arrives with a valid strobe and a start-of-packet marker. A per-packet uncorrectable flag travels with the start byte. The block drives an 8-bit data bus, a data-enable, a packet-sync pulse, an uncorrectable indicator and a clock-enable for the downstream receiver.

Packets whose flag is set are handled in one of two selectable ways.
- In header-marking mode, the packet passes through with its transport error indicator set.
- In masking mode (the reset default), the packet is hidden: sync and enable stay low and every byte becomes FFh.

A 2-bit interface code selects the output format. Three codes give byte-wide output and differ only in how the clock-enable is gated. The fourth code shifts each byte out on bus bit 0. Both configuration inputs take effect only at a packet start. A packet runs from one start byte to the next, and its nominal length is 188 bytes.

Top module: `ts_out_formatter`

## Requirements
- R1: In byte-wide modes (interface code 00, 01 or 10), a byte accepted on a clock edge (inValid and inReady high) appears on outData on the following cycle. If the byte is not masked, outEn is high in that same cycle. Bytes leave in arrival order, one output slot per accepted byte.
- R2: outSync is high only in the output slot (in serial mode, only the first bit) of a byte accepted with inSop high, and only if that packet is not masked.
- R3: The uncorrectable flag is sampled with the start byte. outUncor is high in every output slot, and in serial mode every bit cycle, of a packet whose start byte carried inUncor high. It is low for every other packet.
- R4: With cfgMark=1 at the packet start, the first byte after the start byte of an uncorrectable packet leaves with bit 7 forced to 1. Every other byte, and every byte of a clean packet, is unchanged.
- R5: With cfgMark=0 at the packet start (masking), every byte of an uncorrectable packet leaves as FFh with outEn and outSync low.
- R6: cfgMark and cfgIfSel are sampled only when a start byte is accepted. A change mid-packet has no effect until the next start byte.
- R7: Interface code 11 (serial) shifts each byte MSB first on outData[0] over 8 consecutive cycles, with outData[7:1] zero. outEn and outUncor span all 8 bit cycles.
- R8: In serial mode, inReady is low from the cycle after a byte is accepted until the cycle showing that byte's last bit, where it is high again. This allows one byte per 8 cycles.
- R9: outClkEn behaves as follows for each interface code:
  - 00: always high.
  - 01: high only in slots with outEn high.
  - 10: high in every byte slot, masked or not, and low when idle.
  - 11: high in every bit cycle and low when idle.
- R10: A start byte that is not 47h still passes through unchanged and sets syncErr on the next cycle. syncErr stays high until reset.
- R11: While reset is active and after it ends, with no input, outData, outEn, outSync, outUncor and syncErr are low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input byte valid |
| inSop | input | 1 | Input byte is the first of a packet |
| inUncor | input | 1 | Packet is uncorrectable (sampled with inSop) |
| inByte | input | 8 | Input transport byte |
| cfgMark | input | 1 | 1: header-marking, 0: masking of bad packets |
| cfgIfSel | input | 2 | Interface code: 00/01/10 byte-wide, 11 serial |
| inReady | output | 1 | Block can accept a byte this cycle |
| outData | output | 8 | Output bus; serial data on bit 0 |
| outEn | output | 1 | Bus carries valid data |
| outSync | output | 1 | Sync byte (or its first bit) on the bus |
| outUncor | output | 1 | Current slot belongs to an uncorrectable packet |
| outClkEn | output | 1 | Clock-enable for the downstream receiver |
| syncErr | output | 1 | Sticky: a start byte was not 47h |

## Verification
In byte-wide modes, each byte's output slot is due exactly one cycle after the edge that accepts it. In serial mode, its eight bit cycles follow back to back from that same cycle. syncErr is due on the cycle after the faulty start byte is accepted. inReady falls on the cycle right after a serial acceptance and returns on the eighth.

The driver builds each expected slot at the moment of acceptance and queues it. The monitor samples on falling edges and pops one entry for every cycle in which outEn or outUncor is high, so a slot that is late, early, missing or extra shows up as a mismatch. Idle clock-enable levels, inReady and syncErr are checked at falling edges counted from the last acceptance.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;

  typedef enum logic [1:0] {
    IF_FREE    = 2'b00,
    IF_GATED   = 2'b01,
    IF_PERBYTE = 2'b10,
    IF_SERIAL  = 2'b11
  } ifSel_e;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic   load;    // byte accepted this cycle
    logic   isSync;  // accepted byte opens a packet
    logic   uncor;   // byte belongs to an uncorrectable packet
    logic   setTei;  // force header error bit on this byte
    logic   mask;    // replace byte with null, drop enable/sync
    logic   shift;   // advance serial shifter (not last bit)
    ifSel_e ifSel;   // interface in force for this cycle
  } fmtStrobe_t;

endpackage

// File: rtl/ts_fmt_ctrl.sv
module ts_fmt_ctrl
  import ts_fmt_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  SYNC_BYTE = 8'h47
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inUncor,
  input  logic [DATA_W-1:0] inByte,
  input  logic              cfgMark,
  input  logic [1:0]        cfgIfSel,
  output logic              inReady,
  output logic              syncErr,
  output fmtStrobe_t        strb
);

  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  ifSel_e           activeIf;
  logic             activeMark;
  logic             pktUncor;
  logic             afterSop;
  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             syncErrQ;

  logic   lastBit, accept, startNow, effMark, effUncor;
  ifSel_e effIf;

  always_comb begin
    lastBit  = busy && (bitCnt == LAST_BIT);
    inReady  = !busy || lastBit;
    accept   = inValid && inReady;
    startNow = accept && inSop;
    effIf    = startNow ? ifSel_e'(cfgIfSel) : activeIf;
    effMark  = startNow ? cfgMark : activeMark;
    effUncor = startNow ? inUncor : pktUncor;

    strb.load   = accept;
    strb.isSync = startNow;
    strb.uncor  = effUncor;
    strb.setTei = accept && afterSop && !inSop && effUncor && effMark;
    strb.mask   = effUncor && !effMark;
    strb.shift  = busy && !lastBit;
    strb.ifSel  = effIf;
  end

  assign syncErr = syncErrQ;

  // Packet-level configuration captured at start bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeIf   <= IF_FREE;
      activeMark <= 1'b0;
      pktUncor   <= 1'b0;
      afterSop   <= 1'b0;
      syncErrQ   <= 1'b0;
    end else begin
      if (startNow) begin
        activeIf   <= ifSel_e'(cfgIfSel);
        activeMark <= cfgMark;
        pktUncor   <= inUncor;
        if (inByte[7:0] != SYNC_BYTE) syncErrQ <= 1'b1;
      end
      if (accept) afterSop <= inSop;
    end
  end

  // Serial bit sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (accept && (effIf == IF_SERIAL)) begin
      busy   <= 1'b1;
      bitCnt <= '0;
    end else if (lastBit) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (busy) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  AST_SERIAL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    (accept && effIf == IF_SERIAL) |=> !inReady); // R8

  AST_SYNC_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    syncErrQ |=> syncErrQ); // R10

endmodule

// File: rtl/ts_fmt_datapath.sv
module ts_fmt_datapath
  import ts_fmt_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  NULL_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inByte,
  input  fmtStrobe_t        strb,
  output logic [DATA_W-1:0] outData,
  output logic              outEn,
  output logic              outSync,
  output logic              outUncor,
  output logic              outClkEn
);

  localparam logic [DATA_W-1:0] TEI_BIT  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] NULL_VAL = DATA_W'(NULL_BYTE);
  localparam logic [DATA_W-2:0] UPPER_0  = '0;

  logic [DATA_W-1:0] fmtByte;
  logic [DATA_W-1:0] shReg;
  logic              holdEn;
  logic              holdUncor;

  always_comb begin
    if (strb.mask)        fmtByte = NULL_VAL;
    else if (strb.setTei) fmtByte = inByte | TEI_BIT;
    else                  fmtByte = inByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData   <= '0;
      outEn     <= 1'b0;
      outSync   <= 1'b0;
      outUncor  <= 1'b0;
      outClkEn  <= 1'b0;
      shReg     <= '0;
      holdEn    <= 1'b0;
      holdUncor <= 1'b0;
    end else if (strb.load) begin
      outUncor <= strb.uncor;
      outEn    <= !strb.mask;
      outSync  <= strb.isSync && !strb.mask;
      if (strb.ifSel == IF_SERIAL) begin
        outData   <= {UPPER_0, fmtByte[DATA_W-1]};
        shReg     <= {fmtByte[DATA_W-2:0], 1'b0};
        holdEn    <= !strb.mask;
        holdUncor <= strb.uncor;
        outClkEn  <= 1'b1;
      end else begin
        outData  <= fmtByte;
        outClkEn <= (strb.ifSel == IF_GATED) ? !strb.mask : 1'b1;
      end
    end else if (strb.shift) begin
      outData  <= {UPPER_0, shReg[DATA_W-1]};
      shReg    <= {shReg[DATA_W-2:0], 1'b0};
      outSync  <= 1'b0;
      outEn    <= holdEn;
      outUncor <= holdUncor;
      outClkEn <= 1'b1;
    end else begin
      outEn    <= 1'b0;
      outSync  <= 1'b0;
      outUncor <= 1'b0;
      outClkEn <= (strb.ifSel == IF_FREE);
    end
  end

  AST_SYNC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    outSync |-> outEn); // R2

  AST_MASKED_IS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (outUncor && !outEn) |-> outData[0]); // R5

  AST_SERIAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.ifSel == IF_SERIAL) |=> (outData[DATA_W-1:1] == UPPER_0)); // R7

  AST_SERIAL_CLKEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> outClkEn); // R9

endmodule

// File: rtl/ts_out_formatter.sv
module ts_out_formatter
  import ts_fmt_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  SYNC_BYTE = 8'h47,
  parameter logic [7:0]  NULL_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inUncor,
  input  logic [DATA_W-1:0] inByte,
  input  logic              cfgMark,
  input  logic [1:0]        cfgIfSel,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outEn,
  output logic              outSync,
  output logic              outUncor,
  output logic              outClkEn,
  output logic              syncErr
);

  fmtStrobe_t strb;

  ts_fmt_ctrl #(
    .DATA_W   (DATA_W),
    .SYNC_BYTE(SYNC_BYTE)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSop   (inSop),
    .inUncor (inUncor),
    .inByte  (inByte),
    .cfgMark (cfgMark),
    .cfgIfSel(cfgIfSel),
    .inReady (inReady),
    .syncErr (syncErr),
    .strb    (strb)
  );

  ts_fmt_datapath #(
    .DATA_W   (DATA_W),
    .NULL_BYTE(NULL_BYTE)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .strb    (strb),
    .outData (outData),
    .outEn   (outEn),
    .outSync (outSync),
    .outUncor(outUncor),
    .outClkEn(outClkEn)
  );

endmodule

// File: tb/tb_ts_out_formatter.sv
`timescale 1ns/1ps
module tb_ts_out_formatter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0, inSop = 1'b0, inUncor = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       cfgMark = 1'b0;
  logic [1:0] cfgIfSel = 2'b00;
  logic       inReady, outEn, outSync, outUncor, outClkEn, syncErr;
  logic [7:0] outData;

  always #5 clk = ~clk;

  ts_out_formatter dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop),
    .inUncor(inUncor), .inByte(inByte), .cfgMark(cfgMark),
    .cfgIfSel(cfgIfSel), .inReady(inReady), .outData(outData),
    .outEn(outEn), .outSync(outSync), .outUncor(outUncor),
    .outClkEn(outClkEn), .syncErr(syncErr)
  );

  typedef struct {
    logic [7:0] d;
    logic       en, sync, unc, ce;
    string      tag;
  } item_t;

  item_t expQ[$];
  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;

  // reference model state, from the requirements
  logic       mMark = 1'b0, mUncor = 1'b0, mAfterSop = 1'b0;
  logic [1:0] mIf = 2'b00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic sop, input logic unc, input string tag);
    logic       msk;
    logic [7:0] ob;
    item_t      it;
    @(negedge clk);
    inValid = 1'b1; inByte = b; inSop = sop; inUncor = unc;
    while (!inReady) @(negedge clk);
    if (sop) begin mMark = cfgMark; mIf = cfgIfSel; mUncor = unc; end
    msk = mUncor && !mMark;
    if (msk) ob = 8'hFF;
    else if (mAfterSop && !sop && mUncor && mMark) ob = b | 8'h80;
    else ob = b;
    mAfterSop = sop;
    if (mIf != 2'b11) begin
      it.d = ob; it.en = !msk; it.sync = sop && !msk; it.unc = mUncor;
      it.ce = (mIf == 2'b01) ? !msk : 1'b1; it.tag = tag;
      expQ.push_back(it);
    end else begin
      for (int i = 0; i < 8; i++) begin
        it.d = {7'b0, ob[7-i]}; it.en = !msk; it.sync = sop && !msk && (i == 0);
        it.unc = mUncor; it.ce = 1'b1; it.tag = tag;
        expQ.push_back(it);
      end
    end
    @(posedge clk);
    #1 inValid = 1'b0; inSop = 1'b0;
  endtask

  task automatic sendPkt(input int len, input logic unc, input logic [7:0] seed, input string tag);
    sendByte(8'h47, 1'b1, unc, tag);
    for (int i = 1; i < len; i++) sendByte(8'(seed + i), 1'b0, 1'b0, tag);
  endtask

  task automatic waitDrain();
    repeat (12) @(negedge clk);
  endtask

  // monitor: one expected entry per active output slot
  always @(negedge clk) begin
    if (rstN && (outEn || outUncor)) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R1 unexpected slot", int'(outData), 0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        chk({outData, outEn, outSync, outUncor, outClkEn} == {e.d, e.en, e.sync, e.unc, e.ce},
            e.tag, int'({outData, outEn, outSync, outUncor, outClkEn}),
            int'({e.d, e.en, e.sync, e.unc, e.ce}));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 during and after reset
    chk(!outEn && !outSync && !outUncor && !syncErr && outData == 0 && inReady, "R11 in reset",
        int'({outData, outEn, outSync, outUncor, syncErr, inReady}), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!outEn && !outSync && !outUncor && !syncErr && outData == 0 && inReady, "R11 after reset",
        int'({outData, outEn, outSync, outUncor, syncErr, inReady}), 1);

    // R1 R2: clean packet, free-running interface
    cfgIfSel = 2'b00; cfgMark = 1'b0;
    sendPkt(6, 1'b0, 8'h10, "R1 R2 clean parallel");
    @(negedge clk); @(negedge clk);
    chk(outClkEn == 1'b1, "R9 code00 idle clkEn", outClkEn, 1);

    // R5 R3: masking of uncorrectable packet
    sendPkt(5, 1'b1, 8'h20, "R5 R3 masked parallel");
    sendPkt(3, 1'b0, 8'h30, "R3 clean after masked");

    // R4: header marking
    cfgMark = 1'b1;
    sendByte(8'h47, 1'b1, 1'b1, "R4 mark sync");
    sendByte(8'h12, 1'b0, 1'b0, "R4 tei forced");
    sendByte(8'h34, 1'b0, 1'b0, "R4 later byte unchanged");
    sendPkt(3, 1'b0, 8'h40, "R4 clean packet unchanged");

    // R6: configuration change mid-packet is ignored until next start
    sendByte(8'h47, 1'b1, 1'b1, "R6 start marked");
    cfgMark = 1'b0; cfgIfSel = 2'b11;
    sendByte(8'h05, 1'b0, 1'b0, "R6 still marked parallel");
    sendByte(8'h06, 1'b0, 1'b0, "R6 still marked parallel");

    // R7 R8: serial packet (next start picks up code 11, masking)
    sendByte(8'h47, 1'b1, 1'b0, "R7 serial sync");
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      chk(inReady == 1'b0, "R8 busy while shifting", inReady, 0);
    end
    @(negedge clk);
    chk(inReady == 1'b1, "R8 ready on last bit", inReady, 1);
    sendByte(8'hA5, 1'b0, 1'b0, "R7 serial data");
    sendByte(8'h3C, 1'b0, 1'b0, "R7 serial data");
    waitDrain();
    chk(outClkEn == 1'b0, "R9 code11 idle clkEn", outClkEn, 0);
    sendPkt(2, 1'b1, 8'h50, "R7 R5 serial masked");
    waitDrain();

    // R9: gated interface hides masked slots
    cfgIfSel = 2'b01;
    sendPkt(3, 1'b1, 8'h60, "R9 code01 masked");
    sendPkt(3, 1'b0, 8'h70, "R9 code01 clean");
    @(negedge clk); @(negedge clk);
    chk(outClkEn == 1'b0, "R9 code01 idle clkEn", outClkEn, 0);

    // R9: per-byte interface pulses also on masked slots
    cfgIfSel = 2'b10;
    sendPkt(3, 1'b1, 8'h80, "R9 code10 masked");
    sendPkt(2, 1'b0, 8'h90, "R9 code10 clean");
    @(negedge clk); @(negedge clk);
    chk(outClkEn == 1'b0, "R9 code10 idle clkEn", outClkEn, 0);

    // R10: bad sync byte passes and sets sticky error
    cfgIfSel = 2'b00;
    chk(syncErr == 1'b0, "R10 no error yet", syncErr, 0);
    sendByte(8'h55, 1'b1, 1'b0, "R10 bad start passes");
    sendByte(8'h01, 1'b0, 1'b0, "R10 payload");
    chk(syncErr == 1'b1, "R10 error set", syncErr, 1);

    // R1: full-length packet after the error
    sendPkt(188, 1'b0, 8'h00, "R1 full packet");
    waitDrain();
    chk(syncErr == 1'b1, "R10 error sticky", syncErr, 1);
    chk(expQ.size() == 0, "R1 all slots seen", expQ.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule